// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port controlled through a small word-addressed register file on a 32-bit read/write bus. Software chooses a direction for each pin. Output pins are driven from a stored data word. The synchronized pad levels can be read at any time.

Each pin has its own interrupt detector. The detector fires on a low level, a high level, a rising edge or a falling edge, as chosen by a two-bit field. A separate per-pin override bit makes the pin fire on every change instead. Detected events collect in a sticky status word, which software clears by writing ones. A mask word gates which pending bits reach the two request lines. One line serves pins 0 to 15 and the other serves pins 16 to 31.

A bus write takes effect at the clock edge on which `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, every register reads zero, `pad_oe` and `pad_out` are zero, and both request lines are low.
- R2: Register index 0 (output data) and index 1 (direction) read back the last value written. `pad_out` follows index 0. `pad_oe` follows index 1, and a 1 makes that pin an output.
- R3: Index 2 returns the pad levels through a two-flop synchronizer. A pad change made before a clock edge is visible in a read after the second edge, not after the first.
- R4: Pins 0–15 take their trigger field from index 3, and pins 16–31 take it from index 4. The field sits at bits [2·(pin mod 16)+1 : 2·(pin mod 16)].
- R5: Field code 00 selects low level, 01 high level, 10 rising edge and 11 falling edge. In a level mode the status bit is set again on every cycle the level holds, so a clear has no lasting effect.
- R6: In an edge mode the status bit is set once per matching edge of the synchronized input. It stays clear after a clear write, and the opposite edge does not set it.
- R7: A 1 in index 7 (dual-edge) makes the pin fire on both edges and ignores its trigger field. A level no longer re-sets the bit.
- R8: Index 6 is the sticky status word. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: A detected event and a clear write to the same bit on the same edge leave the bit set.
- R10: `irq_lo` is high when any of pins 0–15 has both its status bit and its index 5 mask bit set. `irq_hi` does the same for pins 16–31. Pending bits with mask 0 raise neither line.
- R11: Writes to index 2 are ignored. Index 2 always returns the synchronized pads.
- R12: A pad edge reaches the status register on the third clock edge after the change, because the path has two synchronizer flops and then the status flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Output data to pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Request line for pins 0–15 |
| irq_hi | output | 1 | Request line for pins 16–31 |

## Verification
A detector event can land on the same clock edge as a software clear of that status bit. The bench provokes this by writing the clear on the third edge after a rising pad transition on an edge-mode pin. It judges the result by reading the status bit back, which must still be set.

A level-mode pin gives the same collision on every cycle. There, the bench expects a clear written while the level holds to have no visible effect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned NPIN    = 32;
    localparam int unsigned DATA_W  = NPIN;
    localparam int unsigned IDX_W   = 3;
    localparam int unsigned FIELD_W = 2;
    localparam int unsigned HALF    = NPIN / 2;

    typedef enum logic [IDX_W-1:0] {
        IDX_DOUT    = 3'd0,
        IDX_DIR     = 3'd1,
        IDX_PADS    = 3'd2,
        IDX_TRIG_LO = 3'd3,
        IDX_TRIG_HI = 3'd4,
        IDX_MASK    = 3'd5,
        IDX_STAT    = 3'd6,
        IDX_DUAL    = 3'd7
    } reg_idx_e;

    typedef enum logic [FIELD_W-1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] trig_lo;
        logic [DATA_W-1:0] trig_hi;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] dual;
    } cfg_regs_t;

    // Pick the trigger field of one pin from the lower or upper config word.
    function automatic trig_e pin_trig(input logic [DATA_W-1:0] lo,
                                       input logic [DATA_W-1:0] hi,
                                       input int unsigned       pin,
                                       input int unsigned       half);
        logic [DATA_W-1:0] word;
        word = (pin < half) ? lo : hi;
        return trig_e'(word[FIELD_W*(pin % half) +: FIELD_W]);
    endfunction

    // Evaluate one trigger mode against the current and previous sample.
    function automatic logic trig_hit(input trig_e mode, input logic cur, input logic old);
        logic hit;
        case (mode)
            TRIG_LOW:  hit = ~cur;
            TRIG_HIGH: hit = cur;
            TRIG_RISE: hit = cur & ~old;
            default:   hit = ~cur & old;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (chain[0] == $past(d)));  // R3
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N = NPIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      pin_sync,
    input  logic [DATA_W-1:0] trig_lo,
    input  logic [DATA_W-1:0] trig_hi,
    input  logic [N-1:0]      dual,
    output logic [N-1:0]      evt
);
    localparam int unsigned HALF_N = N / 2;

    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= pin_sync;
    end

    for (genvar p = 0; p < N; p++) begin : g_pin
        assign evt[p] = dual[p] ? (pin_sync[p] ^ prev[p])
                                : trig_hit(pin_trig(trig_lo, trig_hi, p, HALF_N),
                                           pin_sync[p], prev[p]);
    end

    AST_DUAL_ONLY_CHANGE: assert property (@(posedge clk) disable iff (rst)
        ((evt & dual & ~(pin_sync ^ prev)) == '0));  // R7
    AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (prev == $past(pin_sync)));  // R6
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] stat
);
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr_vec) | set_vec;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat & $past(set_vec)) == $past(set_vec)));  // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat & $past(clr_vec & ~set_vec)) == '0));  // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        ((stat & ~$past(stat) & ~$past(set_vec)) == '0));  // R6
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    cfg_regs_t         cfg;
    logic [NPIN-1:0]   pad_sync;
    logic [NPIN-1:0]   evt;
    logic [NPIN-1:0]   stat;
    logic [NPIN-1:0]   clr_vec;
    reg_idx_e          idx;

    assign idx = reg_idx_e'(bus_addr);

    gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    gpio_irq_detect #(.N(NPIN)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .pin_sync (pad_sync),
        .trig_lo  (cfg.trig_lo),
        .trig_hi  (cfg.trig_hi),
        .dual     (cfg.dual),
        .evt      (evt)
    );

    assign clr_vec = (bus_we && idx == IDX_STAT) ? bus_wdata : '0;

    gpio_irq_status #(.N(NPIN)) u_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (evt),
        .clr_vec (clr_vec),
        .stat    (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (bus_we) begin
            case (idx)
                IDX_DOUT:    cfg.dout    <= bus_wdata;
                IDX_DIR:     cfg.dir     <= bus_wdata;
                IDX_TRIG_LO: cfg.trig_lo <= bus_wdata;
                IDX_TRIG_HI: cfg.trig_hi <= bus_wdata;
                IDX_MASK:    cfg.mask    <= bus_wdata;
                IDX_DUAL:    cfg.dual    <= bus_wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IDX_DOUT:    bus_rdata = cfg.dout;
            IDX_DIR:     bus_rdata = cfg.dir;
            IDX_PADS:    bus_rdata = pad_sync;
            IDX_TRIG_LO: bus_rdata = cfg.trig_lo;
            IDX_TRIG_HI: bus_rdata = cfg.trig_hi;
            IDX_MASK:    bus_rdata = cfg.mask;
            IDX_STAT:    bus_rdata = stat;
            default:     bus_rdata = cfg.dual;
        endcase
    end

    assign pad_out = cfg.dout;
    assign pad_oe  = cfg.dir;
    assign irq_lo  = |(stat[HALF-1:0]    & cfg.mask[HALF-1:0]);
    assign irq_hi  = |(stat[NPIN-1:HALF] & cfg.mask[NPIN-1:HALF]);

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == IDX_DIR) |=> (pad_oe == $past(bus_wdata)));  // R2
    AST_PADS_READONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == IDX_PADS) |=> $stable(cfg));  // R11
    AST_IRQ_LO_MASKED: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> (|cfg.mask[HALF-1:0]));  // R10
    AST_IRQ_HI_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq_hi |-> (|stat[NPIN-1:HALF]));  // R10
endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
    import gpio_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [IDX_W-1:0]  bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NPIN-1:0]   pad_in = 32'h1234_5678;
    logic [NPIN-1:0]   pad_out;
    logic [NPIN-1:0]   pad_oe;
    logic              irq_lo;
    logic              irq_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    typedef struct packed {
        logic [IDX_W-1:0]  a;
        logic [DATA_W-1:0] w;
        logic [DATA_W-1:0] e;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{3'd0, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
        '{3'd1, 32'h0000_FFFF, 32'h0000_FFFF},
        '{3'd3, 32'h1357_9BDF, 32'h1357_9BDF},
        '{3'd4, 32'h2468_ACE0, 32'h2468_ACE0},
        '{3'd5, 32'h0F0F_0000, 32'h0F0F_0000},
        '{3'd7, 32'h8000_0001, 32'h8000_0001},
        '{3'd2, 32'hDEAD_BEEF, 32'h1234_5678}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [IDX_W-1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [IDX_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] r;
        tick(3);
        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd(i[2:0], r);
            check("R1 reg zero in reset", r, 32'h0);
        end
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 irq lines", {30'h0, irq_hi, irq_lo}, 32'h0);
        rst = 1'b0;
        tick(3);

        // R2, R11: register vectors
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i].a, VEC[i].w);
            rd(VEC[i].a, r);
            check(VEC[i].a == 3'd2 ? "R11 pads ignore write" : "R2 readback", r, VEC[i].e);
        end
        check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
        check("R2 pad_oe", pad_oe, 32'h0000_FFFF);
        wr(3'd3, 32'h0); wr(3'd4, 32'h0); wr(3'd5, 32'h0); wr(3'd7, 32'h0);

        // R3: two-flop synchronizer latency
        pad_in = 32'hFFFF_FFFF;
        tick(1); rd(3'd2, r);
        check("R3 after one edge", r, 32'h1234_5678);
        tick(1); rd(3'd2, r);
        check("R3 after two edges", r, 32'hFFFF_FFFF);
        tick(2);

        // Config: pin3 rise (lo word), pin17 fall, pin20 high (hi word), pin5 dual
        wr(3'd3, 32'h0000_0080);
        wr(3'd4, 32'h0000_010C);
        wr(3'd7, 32'h0000_0020);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, r);
        check("R5 high level re-sets after clear (R4 upper word)", r, 32'h0010_0000);
        check("R10 masked pending gives no irq", {30'h0, irq_hi, irq_lo}, 32'h0);

        // R6: rising edge on pin3
        pad_in[3] = 1'b0; tick(3); rd(3'd6, r);
        check("R6 falling edge ignored in rise mode", r & 32'h8, 32'h0);
        pad_in[3] = 1'b1; tick(2); rd(3'd6, r);
        check("R12 not set after two edges", r & 32'h8, 32'h0);
        tick(1); rd(3'd6, r);
        check("R12 R6 rise sets on third edge", r, 32'h0010_0008);
        wr(3'd6, 32'h0000_0008); rd(3'd6, r);
        check("R8 R6 edge bit clears", r, 32'h0010_0000);

        // R4, R5: falling mode on pin17
        pad_in[17] = 1'b0; tick(3); rd(3'd6, r);
        check("R4 R5 fall code 11 on pin17", r, 32'h0012_0000);
        wr(3'd6, 32'h0002_0000);
        pad_in[17] = 1'b1; tick(3); rd(3'd6, r);
        check("R6 rise ignored in fall mode", r, 32'h0010_0000);

        // R7: dual edge overrides low-level field on pin5
        pad_in[5] = 1'b0; tick(3); rd(3'd6, r);
        check("R7 dual falling", r & 32'h20, 32'h20);
        wr(3'd6, 32'h0000_0020); tick(2); rd(3'd6, r);
        check("R7 field ignored, no level re-set", r & 32'h20, 32'h0);
        pad_in[5] = 1'b1; tick(3); rd(3'd6, r);
        check("R7 dual rising", r & 32'h20, 32'h20);
        wr(3'd6, 32'h0000_0020);

        // R5: low level on pin0 (default field 00)
        pad_in[0] = 1'b0; tick(3);
        wr(3'd6, 32'h0000_0001); rd(3'd6, r);
        check("R5 low level survives clear", r & 32'h1, 32'h1);
        pad_in[0] = 1'b1; tick(3);
        wr(3'd6, 32'h0000_0001); rd(3'd6, r);
        check("R8 cleared once level gone", r & 32'h1, 32'h0);

        // R10: mask and half split
        wr(3'd5, 32'h0010_0000);
        check("R10 irq_hi from pin20", {30'h0, irq_hi, irq_lo}, 32'h2);
        wr(3'd5, 32'h0000_0008);
        pad_in[3] = 1'b0; tick(3);
        pad_in[3] = 1'b1; tick(3);
        check("R10 irq_lo from pin3", {30'h0, irq_hi, irq_lo}, 32'h1);
        wr(3'd6, 32'h0000_0008);
        check("R10 irq_lo drops after clear", {30'h0, irq_hi, irq_lo}, 32'h0);

        // R9: set and clear on the same edge
        pad_in[3] = 1'b0; tick(3);
        pad_in[3] = 1'b1; tick(2);
        wr(3'd6, 32'h0000_0008);
        rd(3'd6, r);
        check("R9 set wins over clear", r & 32'h8, 32'h8);
        check("R9 irq_lo held", {31'h0, irq_lo}, 32'h1);

        summary();
    end
endmodule